// File: doc/BRIEF.md
# Shadow-Loaded Pulse Generator

This block is a free-running pulse generator with a counter of twice the bus width, 32 bits by default. It drives one output pin that alternates between an asserted phase and a deasserted phase. The asserted phase lasts for the programmed width. The deasserted phase lasts for the rest of the programmed period. A status flag and an interrupt line are raised once per period so that software can pace real-time work.

Software reaches the block over a plain register port. Each write is one cycle with `bus_wr` high. Reads are combinational on `bus_addr`. Period and width are split into 16-bit halves. Writing any half only updates a pending copy. The pending period and the full pending width move into the working copy together, on the same edge that captures a write to the width low half. Software that changes only the period can read the width low half and write the same value back to commit it.

The counter does not count down to zero. On each phase start it loads the bitwise complement of the phase length and counts up by one per clock to the fixed terminal value `2^32-2`. When the counter reaches that value, the next phase is loaded.

Top module: `pwm_timer`

## Requirements
- R1: After reset the output is high (the deasserted level for active-low polarity), `irq` is low, and every register reads 0. The register addresses are: control 0, status 1, period low 2, period high 3, width low 4, width high 5.
- R2: Take P as the committed period and W as the committed width. Suppose the enable bit (control bit 0) is captured at edge k. The output is then asserted for the W cycles that follow edge k+1, deasserted for P−W cycles, and this repeats with period P for as long as the timer stays enabled.
- R3: Control bit 1 selects the polarity. When it is set, the asserted level is 1 and the deasserted level is 0. When it is clear, the asserted level is 0 and the deasserted level is 1.
- R4: Writes to addresses 2, 3 and 5 do not change the waveform. The edge that captures a write to address 4 copies the whole pending period and width into the working registers. A read of addresses 2 to 5 returns the pending half.
- R5: A commit made while the timer runs never shortens the phase in progress. The new values apply from the next phase boundary onward.
- R6: Status bit 0 is set at every period expiry, which is the edge that ends a deasserted phase. Writing 1 to status bit 0 clears it. If an expiry and a clear fall on the same edge, the set wins. `irq` equals status bit 0 AND control bit 2.
- R7: The settings are invalid when the width is 0 or the period is not greater than the width. If the settings are invalid when a start or a phase boundary is evaluated, the counter idles, the output stays deasserted, and status bit 1 is set. Clearing the enable bit clears status bit 1.
- R8: The edge that captures a write clearing the enable bit also drives the output to its deasserted level. The working registers keep their values, so enabling again without a commit gives the same waveform.
- R9: The high halves supply bits 31:16, so a width above 65535 cycles is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| pwm_out | output | 1 | Pulse output |
| irq | output | 1 | Interrupt, period status AND interrupt enable |

## Verification
Most internal faults show up on `pwm_out` within one period:

- A wrong preload, a wrong terminal value or a wrong reload difference shifts an output edge by at least one cycle.
- A phase register that is stuck or swapped inverts the output for a whole phase.
- Early use of the pending registers changes the phase length right after the uncommitted write.

Faults in the status and interrupt logic show on `irq` or in a status read. A missed or double expiry shows exactly P cycles after the start. A broken write-1-to-clear shows on the edge after the status write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] RA_PLO  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_PHI  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_WLO  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_WHI  = 3'd5;

  // control bit positions
  localparam int CB_EN  = 0;
  localparam int CB_POL = 1;
  localparam int CB_IE  = 2;
  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACT   = 2'd1,
    PH_INACT = 2'd2
  } phase_e;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] shd_per,
  output logic [2*HALF_W-1:0] shd_wid,
  output logic [2*HALF_W-1:0] act_per,
  output logic [2*HALF_W-1:0] act_wid
);

  localparam int CNT_W = 2 * HALF_W;
  localparam int NHALF = 2;

  logic [NHALF-1:0][HALF_W-1:0] per_q, wid_q;
  logic [CNT_W-1:0]             act_per_q, act_wid_q;
  logic                         commit;
  logic [CNT_W-1:0]             wid_commit;

  assign commit     = wr && (addr == RA_WLO);
  assign wid_commit = {wid_q[1], wdata};

  // pending halves: the period halves sit at PLO+h, the width halves at WLO+h
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      wid_q <= '0;
    end else if (wr) begin
      for (int h = 0; h < NHALF; h++) begin
        if (addr == RA_PLO + ADDR_W'(h)) per_q[h] <= wdata;
        if (addr == RA_WLO + ADDR_W'(h)) wid_q[h] <= wdata;
      end
    end
  end

  // working copy, loaded as one unit by the width-low write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per_q <= '0;
      act_wid_q <= '0;
    end else if (commit) begin
      act_per_q <= per_q;
      act_wid_q <= wid_commit;
    end
  end

  assign shd_per = per_q;
  assign shd_wid = wid_q;
  assign act_per = act_per_q;
  assign act_wid = act_wid_q;

endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              period_done,
  output logic              ctrl_en,
  output logic              ctrl_pol,
  output logic              ctrl_ie,
  output logic              irq_pend
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q;
  logic              clr_req;

  assign clr_req = wr && (addr == RA_STAT) && wbits[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr && (addr == RA_CTRL)) begin
      ctrl_q <= wbits;
    end
  end

  // a set from an expiry takes priority over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (period_done) begin
      pend_q <= 1'b1;
    end else if (clr_req) begin
      pend_q <= 1'b0;
    end
  end

  assign ctrl_en  = ctrl_q[CB_EN];
  assign ctrl_pol = ctrl_q[CB_POL];
  assign ctrl_ie  = ctrl_q[CB_IE];
  assign irq_pend = pend_q;

endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] wid,
  output logic [CNT_W-1:0] cnt,
  output phase_e           phase,
  output logic             cfg_err,
  output logic             period_done
);

  localparam logic [CNT_W-1:0] TERM = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q;
  logic             err_q;
  logic             settings_ok;
  logic             at_term;
  logic [CNT_W-1:0] act_load, inact_load;

  assign settings_ok = (per > wid) && (wid != '0);
  assign at_term     = (cnt_q == TERM);
  assign act_load    = ~wid;
  assign inact_load  = ~(per - wid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else if (!en) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (!err_q) begin
            if (settings_ok) begin
              cnt_q   <= act_load;
              phase_q <= PH_ACT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        PH_ACT: begin
          if (!at_term) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (settings_ok) begin
            cnt_q   <= inact_load;
            phase_q <= PH_INACT;
          end else begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b1;
          end
        end
        PH_INACT: begin
          if (!at_term) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (settings_ok) begin
            cnt_q   <= act_load;
            phase_q <= PH_ACT;
          end else begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cnt         = cnt_q;
  assign phase       = phase_q;
  assign cfg_err     = err_q;
  assign period_done = en && (phase_q == PH_INACT) && at_term;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              pwm_out,
  output logic              irq
);

  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] shd_per, shd_wid, act_per, act_wid, cnt;
  logic             ctrl_en, ctrl_pol, ctrl_ie, irq_pend;
  logic             cfg_err, period_done;
  phase_e           phase;

  pwm_shadow_regs #(.HALF_W(HALF_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .shd_per (shd_per),
    .shd_wid (shd_wid),
    .act_per (act_per),
    .act_wid (act_wid)
  );

  pwm_ctrl_regs u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .addr        (bus_addr),
    .wbits       (bus_wdata[CTRL_W-1:0]),
    .period_done (period_done),
    .ctrl_en     (ctrl_en),
    .ctrl_pol    (ctrl_pol),
    .ctrl_ie     (ctrl_ie),
    .irq_pend    (irq_pend)
  );

  pwm_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (ctrl_en),
    .per         (act_per),
    .wid         (act_wid),
    .cnt         (cnt),
    .phase       (phase),
    .cfg_err     (cfg_err),
    .period_done (period_done)
  );

  // asserted only while enabled and inside the width phase
  assign pwm_out = (ctrl_en && (phase == PH_ACT)) ? ctrl_pol : ~ctrl_pol;
  assign irq     = irq_pend & ctrl_ie;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL: begin
        bus_rdata[CB_EN]  = ctrl_en;
        bus_rdata[CB_POL] = ctrl_pol;
        bus_rdata[CB_IE]  = ctrl_ie;
      end
      RA_STAT: begin
        bus_rdata[0] = irq_pend;
        bus_rdata[1] = cfg_err;
      end
      RA_PLO:  bus_rdata = shd_per[HALF_W-1:0];
      RA_PHI:  bus_rdata = shd_per[CNT_W-1:HALF_W];
      RA_WLO:  bus_rdata = shd_wid[HALF_W-1:0];
      RA_WHI:  bus_rdata = shd_wid[CNT_W-1:HALF_W];
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                ctrl_en,
  input logic                ctrl_pol,
  input logic                irq_pend,
  input logic                irq,
  input logic                pwm_out,
  input phase_e              phase,
  input logic [2*HALF_W-1:0] cnt,
  input logic [2*HALF_W-1:0] act_per,
  input logic [2*HALF_W-1:0] act_wid,
  input logic                cfg_err,
  input logic                period_done
);

  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] TERM = {{(CNT_W-1){1'b1}}, 1'b0};

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && phase == PH_IDLE && !cfg_err && act_per > act_wid && act_wid != '0)
    |=> (phase == PH_ACT && cnt == ~$past(act_wid)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && phase != PH_IDLE && cnt != TERM) |=> (cnt == $past(cnt) + 1'b1));

  // R5
  width_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && phase == PH_ACT && cnt == TERM && act_per > act_wid && act_wid != '0)
    |=> (phase == PH_INACT && cnt == ~($past(act_per) - $past(act_wid))));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (pwm_out == !ctrl_pol));

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> irq_pend);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_pend);

  // R4
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == RA_WLO) |=> ($stable(act_per) && $stable(act_wid)));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (phase == PH_IDLE));

endmodule

bind pwm_timer pwm_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .ctrl_en     (ctrl_en),
  .ctrl_pol    (ctrl_pol),
  .irq_pend    (irq_pend),
  .irq         (irq),
  .pwm_out     (pwm_out),
  .phase       (phase),
  .cnt         (cnt),
  .act_per     (act_per),
  .act_wid     (act_wid),
  .cfg_err     (cfg_err),
  .period_done (period_done)
);

// File: tb/test_pwm_timer.sv
`timescale 1ns/1ps
module test_pwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_PLO = 3'd2,
                         A_PHI = 3'd3, A_WLO = 3'd4, A_WHI = 3'd5;

  always #2.5 clk = ~clk;

  pwm_timer i_pwm_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .irq       (irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // called at a falling edge; the write is captured at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic program_pw(input int unsigned p, input int unsigned w);
    wr(A_PLO, p[15:0]);
    wr(A_PHI, p[31:16]);
    wr(A_WHI, w[31:16]);
    wr(A_WLO, w[15:0]);
  endtask

  task automatic stop_timer();
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h1);
  endtask

  function automatic bit exp_pin(input int unsigned i, input int unsigned p,
                                 input int unsigned w, input bit pol);
    return ((i % p) < w) ? pol : !pol;
  endfunction

  // entered right after the enable write has been captured
  task automatic check_wave(input int unsigned p, input int unsigned w, input bit pol,
                            input bit ie, input int unsigned n, input string req);
    int bad_w = 0, bad_i = 0;
    int first_w = -1;
    bit e, ei;
    bit got_w = 1'b0;
    bit got_i = 1'b0;
    bit fe_w = 1'b0;
    bit fe_i = 1'b0;
    for (int unsigned i = 0; i < n; i++) begin
      @(negedge clk);
      e  = exp_pin(i, p, w, pol);
      ei = ie && (i >= p);
      if (pwm_out !== e) begin
        if (bad_w == 0) begin first_w = int'(i); got_w = pwm_out; fe_w = e; end
        bad_w++;
      end
      if (irq !== ei) begin
        if (bad_i == 0) begin got_i = irq; fe_i = ei; end
        bad_i++;
      end
    end
    chk(bad_w == 0, req, $sformatf("waveform p=%0d w=%0d pol=%0d cycle %0d", p, w, pol, first_w),
        got_w, fe_w);
    chk(bad_i == 0, "R6", $sformatf("irq over run p=%0d ie=%0d", p, ie), got_i, fe_i);
  endtask

  initial begin : watchdog
    #(5.0 * 180000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rv;
    logic [15:0] acc;
    int unsigned p, w;
    bit pol, ie;
    int bad;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(pwm_out === 1'b1, "R1", "pwm_out after reset", pwm_out, 1);
    chk(irq === 1'b0, "R1", "irq after reset", irq, 0);
    acc = '0;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv);
      acc |= rv;
    end
    chk(acc == 16'h0, "R1", "register contents after reset", acc, 0);

    // R2 R3 randomized waveforms
    for (int r = 0; r < 6; r++) begin
      w   = 1 + $urandom % 12;
      p   = w + 1 + $urandom % 12;
      pol = 1'($urandom % 2);
      ie  = 1'($urandom % 2);
      program_pw(p, w);
      wr(A_CTRL, {13'd0, ie, pol, 1'b1});
      check_wave(p, w, pol, ie, 3 * p, "R2 R3");
      stop_timer();
    end

    // R2 corner: width 1, period 2
    program_pw(2, 1);
    wr(A_CTRL, 16'h3);
    check_wave(2, 1, 1'b1, 1'b0, 8, "R2");
    stop_timer();

    // R6 write-one-to-clear
    program_pw(6, 2);
    wr(A_CTRL, 16'h7);
    check_wave(6, 2, 1'b1, 1'b1, 7, "R6");
    wr(A_STAT, 16'h1);
    chk(irq === 1'b0, "R6", "irq after write-1 clear", irq, 0);
    rd(A_STAT, rv);
    chk(rv[0] == 1'b0, "R6", "status bit0 after clear", rv[0], 0);
    stop_timer();

    // R6 interrupt enable gating: status set, irq stays low
    program_pw(5, 2);
    wr(A_CTRL, 16'h1);
    check_wave(5, 2, 1'b0, 1'b0, 8, "R6");
    rd(A_STAT, rv);
    chk(rv[0] == 1'b1, "R6", "status bit0 set with irq disabled", rv[0], 1);
    stop_timer();

    // R8 disable mid-width, then re-enable without commit
    program_pw(10, 6);
    wr(A_CTRL, 16'h3);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 16'h2);
    chk(pwm_out === 1'b0, "R8", "output right after disable", pwm_out, 0);
    wr(A_CTRL, 16'h3);
    check_wave(10, 6, 1'b1, 1'b0, 20, "R8");
    stop_timer();

    // R4 pending writes do not act until width-low commit
    wr(A_PLO, 16'd30);
    rd(A_PLO, rv);
    chk(rv == 16'd30, "R4", "pending period low readback", rv, 30);
    rd(A_WLO, rv);
    chk(rv == 16'd6, "R4", "pending width low readback", rv, 6);
    wr(A_CTRL, 16'h3);
    check_wave(10, 6, 1'b1, 1'b0, 20, "R4");
    stop_timer();
    wr(A_WLO, 16'd6);
    wr(A_CTRL, 16'h3);
    check_wave(30, 6, 1'b1, 1'b0, 60, "R4");
    stop_timer();

    // R7 invalid settings: zero width, then period equal to width
    program_pw(5, 0);
    wr(A_CTRL, 16'h3);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R7", "output idle with zero width", bad, 0);
    rd(A_STAT, rv);
    chk(rv[1] == 1'b1, "R7", "error bit with zero width", rv[1], 1);
    wr(A_CTRL, 16'h0);
    @(negedge clk);
    rd(A_STAT, rv);
    chk(rv[1] == 1'b0, "R7", "error bit cleared by disable", rv[1], 0);
    program_pw(4, 4);
    wr(A_CTRL, 16'h1);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_out !== 1'b1) bad++;
    end
    rd(A_STAT, rv);
    chk(bad == 0 && rv[1] == 1'b1, "R7", "idle and error with period equal width",
        {bad, rv[1]}, 1);
    stop_timer();

    // R5 commit during the width phase applies from the next boundary
    program_pw(20, 10);
    wr(A_CTRL, 16'h3);
    program_pw(8, 3);
    bad = 0;
    for (int i = 4; i < 45; i++) begin
      bit e;
      @(negedge clk);
      if (i < 10)      e = 1'b1;
      else if (i < 15) e = 1'b0;
      else             e = exp_pin(i - 15, 8, 3, 1'b1);
      if (pwm_out !== e) bad++;
    end
    chk(bad == 0, "R5", "mismatching cycles after mid-run commit", bad, 0);
    stop_timer();

    // R9 width above 16 bits
    program_pw(32'h0001_0006, 32'h0001_0002);
    wr(A_CTRL, 16'h3);
    check_wave(32'h0001_0006, 32'h0001_0002, 1'b1, 1'b0, 32'h0001_0006 + 6, "R9");
    stop_timer();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule